// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that finishes every instruction in one clock. It handles a small load/store instruction set: word load and store, register-register add, subtract, AND, OR, NOR and signed set-less-than, branch-if-equal and an absolute jump. Inside the core are the program counter, a 32-entry register file with two combinational read ports and one write port, sign extension, the ALU and the next-PC selection. There is also an instruction memory and a data memory, each a plain word array. Control has two levels. A main decoder looks only at the opcode and produces the datapath steering plus a 2-bit ALU class. A small second decoder turns that class, together with the function field, into a 4-bit ALU operation code.

Both memories are filled through a word-wide load port before the core runs. The core is observed through its program counter and through two write-trace buses, one for the register file and one for the data memory. Each trace bus shows the write that the current instruction makes at the next rising edge.

Top module: `scc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0 and neither `rf_we_o` nor `dmem_we_o` is asserted. Asserting `rst_n` low in the middle of a run clears `pc_o` at once, without waiting for a clock edge. The core starts fetching from address 0 on the second rising edge after `rst_n` is released.
- R2: For an R-format instruction (opcode 000000), funct 100000 writes rs+rt into rd and funct 100010 writes rs-rt into rd. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: For an R-format instruction, funct 100100 writes rs AND rt and funct 100101 writes rs OR rt.
- R4: For an R-format instruction, funct 101010 writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R5: A load (opcode 100011) writes register rt with the data word at byte address rs + SignExt(imm[15:0]).
- R6: A store (opcode 101011) asserts `dmem_we_o` with address rs + SignExt(imm) and data rt. It makes no register write.
- R7: A branch (opcode 000100) whose rs and rt are equal moves the PC to PC+4 + (SignExt(imm) << 2). This holds for both positive and negative offsets.
- R8: A branch whose operands differ, and every instruction that is neither a taken branch nor a jump, advances the PC by 4.
- R9: A jump (opcode 000010) sets the PC to {PC+4 [31:28], target[25:0], 00} and writes no state.
- R10: Register 0 always reads as zero. A write aimed at register 0 does not take place, so `rf_we_o` is never asserted with address 0.
- R11: An unknown opcode, or an R-format instruction with an unknown funct, writes neither the register file nor the data memory, and the PC advances by 4.
- R12: For an R-format instruction, funct 100111 writes NOR(rs, rt). Inside the core it uses ALU code 1100.
- R13: A load with a negative offset reaches the word below its base register. This shows that the 16-bit immediate is sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 selects the data memory, 0 the instruction memory |
| ld_addr | input | LD_AW | Load-port word index |
| ld_data | input | 32 | Load-port data word |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dmem_we_o | output | 1 | Data-memory write at the next edge |
| dmem_addr_o | output | 32 | Byte address of that write |
| dmem_wdata_o | output | 32 | Data of that write |

## Verification
Each instruction's effects show up combinationally on the trace buses during the cycle in which `pc_o` holds its address. Its PC successor appears one rising edge later. The bench releases reset at a falling edge, lets two rising edges pass for the synchronizer, and compares the first instruction at the next falling edge. After that it compares exactly one instruction per falling edge, so every result is sampled in the cycle it is due. A load's result is seen as its register write. Effects that are meant to be absent, such as a write to register 0 or a write from an unknown instruction, are checked through the write strobes and then by reading the register back in a later instruction.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ACLS_ADD   = 2'b00,
    ACLS_SUB   = 2'b01,
    ACLS_FUNCT = 2'b10
  } alu_class_e;

  localparam logic [3:0] ALUC_AND = 4'b0000;
  localparam logic [3:0] ALUC_OR  = 4'b0001;
  localparam logic [3:0] ALUC_ADD = 4'b0010;
  localparam logic [3:0] ALUC_SUB = 4'b0110;
  localparam logic [3:0] ALUC_SLT = 4'b0111;
  localparam logic [3:0] ALUC_NOR = 4'b1100;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       rf_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/scc_main_dec.sv
module scc_main_dec
  import scc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_class = ACLS_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_write  = 1'b1;
        ctrl.alu_class = ACLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.rf_write    = 1'b1;
        ctrl.mem_read    = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch    = 1'b1;
        ctrl.alu_class = ACLS_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scc_alu_dec.sv
module scc_alu_dec
  import scc_pkg::*;
(
  input  alu_class_e alu_class,
  input  logic [5:0] funct,
  output logic [3:0] alu_ctl,
  output logic       valid
);
  always_comb begin
    alu_ctl = ALUC_ADD;
    valid   = 1'b1;
    unique case (alu_class)
      ACLS_ADD: alu_ctl = ALUC_ADD;
      ACLS_SUB: alu_ctl = ALUC_SUB;
      ACLS_FUNCT: begin
        unique case (funct)
          FN_ADD:  alu_ctl = ALUC_ADD;
          FN_SUB:  alu_ctl = ALUC_SUB;
          FN_AND:  alu_ctl = ALUC_AND;
          FN_OR:   alu_ctl = ALUC_OR;
          FN_NOR:  alu_ctl = ALUC_NOR;
          FN_SLT:  alu_ctl = ALUC_SLT;
          default: valid   = 1'b0;
        endcase
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   ctl,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (ctl)
      ALUC_AND: y = a & b;
      ALUC_OR:  y = a | b;
      ALUC_ADD: y = a + b;
      ALUC_SUB: y = a - b;
      ALUC_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALUC_NOR: y = ~(a | b);
      default:  y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREGS];

  // entry 0 is a constant; only entries 1..NREGS-1 hold flops
  assign regs[0] = '0;
  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic en;
    assign en = we && (wa == AW'(g));
    always_ff @(posedge clk) begin
      if (en) regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W  = $clog2(IMEM_WORDS),
  localparam int DA_W  = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dmem_we_o,
  output logic [31:0]      dmem_addr_o,
  output logic [31:0]      dmem_wdata_o
);
  logic [1:0]      rst_sync_q;
  logic            run_q;
  logic [31:0]     pc_q, pc_next, pc4;
  logic [31:0]     instr;
  logic [31:0]     imem [IMEM_WORDS];
  logic [31:0]     dmem [DMEM_WORDS];
  ctrl_t           ctrl;
  logic [3:0]      alu_ctl;
  logic            alu_ok;
  logic [31:0]     rs_val, rt_val, imm_ext, alu_b, alu_y, rd_mem, wb_val;
  logic            alu_zero;
  logic [4:0]      dst;
  logic            rf_we, dm_we;
  logic [DA_W-1:0] dm_idx;

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run_q = rst_sync_q[1];

  assign instr = imem[pc_q[IA_W+1:2]];

  scc_main_dec u_main_dec (.opcode(instr[31:26]), .ctrl(ctrl));
  scc_alu_dec  u_alu_dec  (.alu_class(ctrl.alu_class), .funct(instr[5:0]),
                           .alu_ctl(alu_ctl), .valid(alu_ok));

  scc_regfile #(.W(32), .NREGS(32)) u_rf (
    .clk(clk), .ra1(instr[25:21]), .ra2(instr[20:16]),
    .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(dst), .wd(wb_val)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

  scc_alu #(.W(32)) u_alu (.a(rs_val), .b(alu_b), .ctl(alu_ctl),
                           .y(alu_y), .zero(alu_zero));

  assign dm_idx = alu_y[DA_W+1:2];
  assign rd_mem = ctrl.mem_read ? dmem[dm_idx] : '0;
  assign wb_val = ctrl.wb_from_mem ? rd_mem : alu_y;
  assign dst    = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign rf_we  = run_q && ctrl.rf_write && alu_ok && (dst != 5'd0);
  assign dm_we  = run_q && ctrl.mem_write;

  // next-PC selection
  assign pc4 = pc_q + 32'd4;
  always_comb begin
    if (ctrl.jump)                  pc_next = {pc4[31:28], instr[25:0], 2'b00};
    else if (ctrl.branch && alu_zero) pc_next = pc4 + {imm_ext[29:0], 2'b00};
    else                            pc_next = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (run_q) pc_q <= pc_next;
  end

  // memories: load port has priority over core stores
  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IA_W-1:0]] <= ld_data;
  end
  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem) dmem[ld_addr[DA_W-1:0]] <= ld_data;
    else if (dm_we)       dmem[dm_idx] <= rt_val;
  end

  assign pc_o         = pc_q;
  assign rf_we_o      = rf_we;
  assign rf_waddr_o   = dst;
  assign rf_wdata_o   = wb_val;
  assign dmem_we_o    = dm_we;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] instr,
  input logic [31:0] pc_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic [31:0] rf_wdata_o,
  input logic        dmem_we_o
);
  logic is_ctl_flow;
  assign is_ctl_flow = (instr[31:26] == 6'b000100) || (instr[31:26] == 6'b000010);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (pc_o == 32'd0) && !rf_we_o && !dmem_we_o);

  p_no_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  p_store_no_regwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we_o |-> !rf_we_o);

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !is_ctl_flow) |=> (pc_o == $past(pc_o) + 32'd4));

  p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && instr[31:26] == 6'b000010) |=>
      (pc_o == {$past(pc_o + 32'd4) >> 28, $past(instr[25:0]), 2'b00}));

  p_slt_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && instr[31:26] == 6'b000000 && instr[5:0] == 6'b101010)
      |-> (rf_wdata_o[31:1] == 31'd0));
endmodule

bind scc_core scc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .instr(instr), .pc_o(pc_o),
  .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
  .dmem_we_o(dmem_we_o)
);

// File: tb/scc_core_tb_top.sv
module scc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic        rf_we_o, dmem_we_o;
  logic [4:0]  rf_waddr_o;

  int n_cmp = 0;
  int n_mis = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  scc_core dut_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dmem_we_o(dmem_we_o), .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare one instruction's cycle, then move to the next falling edge
  task automatic step(input string req, input logic [31:0] pc, input logic rwe,
                      input logic [4:0] ra, input logic [31:0] rv,
                      input logic dwe, input logic [31:0] da, dv);
    cmp(req, "pc", pc_o, pc);
    cmp(req, "rf_we", {31'd0, rf_we_o}, {31'd0, rwe});
    if (rwe) begin
      cmp(req, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, ra});
      cmp(req, "rf_wdata", rf_wdata_o, rv);
    end
    cmp(req, "dmem_we", {31'd0, dmem_we_o}, {31'd0, dwe});
    if (dwe) begin
      cmp(req, "dmem_addr", dmem_addr_o, da);
      cmp(req, "dmem_wdata", dmem_wdata_o, dv);
    end
    @(negedge clk);
  endtask

  task automatic load(input logic dm, input logic [5:0] a, input logic [31:0] d);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp("R1", "pc in reset", pc_o, 32'd0);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "pc held while sync", pc_o, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_arith();
    hold_reset();
    load(1, 0, 32'd100);
    load(1, 1, 32'hFFFF_FFF9);
    load(1, 2, 32'h0F0F_00FF);
    load(1, 3, 32'h00FF_0F0F);
    load(0, 0,  enc_i(6'b100011, 0, 1, 16'd0));
    load(0, 1,  enc_i(6'b100011, 0, 2, 16'd4));
    load(0, 2,  enc_i(6'b100011, 0, 3, 16'd8));
    load(0, 3,  enc_i(6'b100011, 0, 4, 16'd12));
    load(0, 4,  enc_r(1, 2, 5, 6'b100000));
    load(0, 5,  enc_r(1, 2, 6, 6'b100010));
    load(0, 6,  enc_r(3, 4, 7, 6'b100100));
    load(0, 7,  enc_r(3, 4, 8, 6'b100101));
    load(0, 8,  enc_r(2, 1, 9, 6'b101010));
    load(0, 9,  enc_r(1, 2, 10, 6'b101010));
    load(0, 10, enc_r(3, 4, 11, 6'b100111));
    load(0, 11, enc_r(1, 1, 0, 6'b100000));
    load(0, 12, enc_r(0, 0, 12, 6'b100000));
    load(0, 13, enc_i(6'b101011, 1, 6, 16'hFFFC));
    load(0, 14, enc_i(6'b100011, 1, 13, 16'hFFFC));
    load(0, 15, {6'b111111, 26'd0});
    load(0, 16, enc_r(1, 1, 14, 6'b111111));
    // R1: reset still held, no writes shown
    cmp("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
    cmp("R1", "dmem_we in reset", {31'd0, dmem_we_o}, 32'd0);
    release_reset();
    step("R5",  32'd0,  1, 1,  32'd100,        0, 0, 0);
    step("R5",  32'd4,  1, 2,  32'hFFFF_FFF9,  0, 0, 0);
    step("R5",  32'd8,  1, 3,  32'h0F0F_00FF,  0, 0, 0);
    step("R5",  32'd12, 1, 4,  32'h00FF_0F0F,  0, 0, 0);
    step("R2",  32'd16, 1, 5,  32'd93,         0, 0, 0);
    step("R2",  32'd20, 1, 6,  32'd107,        0, 0, 0);
    step("R3",  32'd24, 1, 7,  32'h000F_000F,  0, 0, 0);
    step("R3",  32'd28, 1, 8,  32'h0FFF_0FFF,  0, 0, 0);
    step("R4",  32'd32, 1, 9,  32'd1,          0, 0, 0);
    step("R4",  32'd36, 1, 10, 32'd0,          0, 0, 0);
    step("R12", 32'd40, 1, 11, 32'hF000_F000,  0, 0, 0);
    step("R10", 32'd44, 0, 0,  0,              0, 0, 0);
    step("R10", 32'd48, 1, 12, 32'd0,          0, 0, 0);
    step("R6",  32'd52, 0, 0,  0,              1, 32'd96, 32'd107);
    step("R13", 32'd56, 1, 13, 32'd107,        0, 0, 0);
    step("R11", 32'd60, 0, 0,  0,              0, 0, 0);
    step("R11", 32'd64, 0, 0,  0,              0, 0, 0);
    cmp("R11", "pc after unknown", pc_o, 32'd68);
  endtask

  task automatic t_flow();
    hold_reset();
    load(1, 0, 32'd5);
    load(1, 1, 32'd5);
    load(1, 2, 32'd6);
    load(0, 0,  enc_i(6'b100011, 0, 1, 16'd0));
    load(0, 1,  enc_i(6'b100011, 0, 2, 16'd4));
    load(0, 2,  enc_i(6'b100011, 0, 3, 16'd8));
    load(0, 3,  enc_i(6'b000100, 1, 2, 16'd2));
    load(0, 4,  enc_r(1, 1, 4, 6'b100000));
    load(0, 6,  enc_i(6'b000100, 1, 3, 16'd5));
    load(0, 7,  {6'b000010, 26'd16});
    load(0, 16, enc_i(6'b000100, 0, 0, 16'hFFFF));
    release_reset();
    step("R5", 32'd0,  1, 1, 32'd5, 0, 0, 0);
    step("R5", 32'd4,  1, 2, 32'd5, 0, 0, 0);
    step("R5", 32'd8,  1, 3, 32'd6, 0, 0, 0);
    step("R7", 32'd12, 0, 0, 0,     0, 0, 0);
    step("R8", 32'd24, 0, 0, 0,     0, 0, 0);
    step("R9", 32'd28, 0, 0, 0,     0, 0, 0);
    step("R7", 32'd64, 0, 0, 0,     0, 0, 0);
    step("R7", 32'd64, 0, 0, 0,     0, 0, 0);
    // R1: reset between edges clears the PC without a clock
    #2;
    rst_n = 1'b0;
    #1;
    cmp("R1", "pc async clear", pc_o, 32'd0);
    cmp("R1", "rf_we after clear", {31'd0, rf_we_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
    t_arith();
    t_flow();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule